// File: doc/BRIEF.md
# Access Attribute Resolution Unit

This block works out the effective attributes of every memory reference. For each incoming reference it gives the caching mode, whether that mode is cacheable, and a write-protect flag. It also raises a violation flag when a valid write lands in a protected region. The block compares the upper byte of the address against two programmable address windows. Each window carries a base, a don't-care mask, an enable, a mode and a protect bit. Window 0 takes precedence over window 1. When neither window matches, a default control word supplies the mode and the protect bit. The default mode is kept separately for instruction fetches and for data accesses.

The attribute path is purely combinational, from the address tag and the stored configuration to the result outputs. The configuration sits in registers that are loaded through a single-word write port and that clear on reset. A write changes the results from the next cycle on.

Top module: `acc_attr_unit`

## Requirements
- R1: After reset every window word and the default word read as zero. A data read then resolves to write-through, cacheable, not protected, with no window selected.
- R2: A window matches when it is enabled and ((req_page XOR base) AND NOT mask) is zero. A mask bit of 1 means the corresponding address bit is ignored. A window word holds base in [7:0], mask in [15:8], enable in [16], mode in [18:17] and the protect bit in [19].
- R3: A window whose enable bit is 0 never matches, whatever its base and mask.
- R4: When window 0 matches, its attributes are used and res_sel_win = 2'b01. Otherwise, when window 1 matches, its attributes are used and res_sel_win = 2'b10. res_sel_win never has more than one bit set.
- R5: When no window matches, res_sel_win is 0 and the mode comes from the default word. A data access (req_instr=0) takes bits [1:0] and an instruction fetch (req_instr=1) takes bits [3:2].
- R6: res_wprot is the protect bit of the selected window. When no window matches, it is default-word bit [4].
- R7: Mode codes are 0 write-through, 1 copyback, 2 inhibited-precise and 3 inhibited-imprecise. res_cacheable is 1 exactly for codes 0 and 1.
- R8: res_violation is 1 exactly when req_valid, req_write and res_wprot are all 1. Reads never raise it, and neither do idle cycles.
- R9: A write with cfg_we=1 loads cfg_wdata into window 0 (cfg_sel=0), into window 1 (cfg_sel=1) or into the default word (cfg_sel=2, low 5 bits) at the next clock edge. A write with cfg_sel=3 changes no configuration, so the results stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0/1 window, 2 default, 3 none |
| cfg_wdata | input | 20 | Configuration data word |
| req_valid | input | 1 | Reference present |
| req_write | input | 1 | Reference is a write |
| req_instr | input | 1 | Reference is an instruction fetch |
| req_page | input | 8 | Address bits 31:24 of the reference |
| res_mode | output | 2 | Effective caching mode code |
| res_cacheable | output | 1 | Mode is write-through or copyback |
| res_wprot | output | 1 | Region is write-protected |
| res_violation | output | 1 | Valid write to a protected region |
| res_sel_win | output | 2 | One-hot window that supplied the attributes |

## Verification
The bench builds the block with its defaults: an 8-bit tag and two windows. With those values, directed patterns can place the two windows so that they overlap. This exposes the priority rule, the effect of the mask bits and the disabled-window case. Random configuration writes, including the unused target 3, are mixed with random address tags against a behavioural model. The tags are drawn from a small set near the window bases, so that partial matches and near misses occur often.

// File: rtl/acc_attr_pkg.sv
package acc_attr_pkg;
  typedef enum logic [1:0] {
    CM_WTHRU    = 2'd0,
    CM_COPYB    = 2'd1,
    CM_INH_PREC = 2'd2,
    CM_INH_IMPR = 2'd3
  } cmode_e;

  localparam int DFLT_W = 5;

  function automatic logic mode_cacheable(input logic [1:0] m);
    return (m == CM_WTHRU) || (m == CM_COPYB);
  endfunction

  function automatic logic tag_hit(input logic [7:0] tag, input logic [7:0] base,
                                   input logic [7:0] mask, input logic en);
    return en && (((tag ^ base) & ~mask) == 8'h00);
  endfunction
endpackage

// File: rtl/acc_attr_regs.sv
module acc_attr_regs #(
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = 20,
  parameter int SEL_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [WIN_W-1:0]         cfg_wdata,
  output logic [NUM_WIN*WIN_W-1:0] win_flat,
  output logic [acc_attr_pkg::DFLT_W-1:0] dflt_word
);
  localparam int DW = acc_attr_pkg::DFLT_W;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)
        win_flat[i*WIN_W +: WIN_W] <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(i))
        win_flat[i*WIN_W +: WIN_W] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dflt_word <= '0;
    else if (cfg_we && cfg_sel == SEL_W'(NUM_WIN))
      dflt_word <= cfg_wdata[DW-1:0];
  end
endmodule

// File: rtl/acc_attr_match.sv
module acc_attr_match #(
  parameter int TAG_W = 8,
  parameter int WIN_W = 2*TAG_W + 4
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [WIN_W-1:0] win_word,
  output logic             hit,
  output logic             en,
  output logic [1:0]       mode,
  output logic             wp
);
  logic [TAG_W-1:0] base, mask;

  assign base = win_word[TAG_W-1:0];
  assign mask = win_word[2*TAG_W-1:TAG_W];
  assign en   = win_word[2*TAG_W];
  assign mode = win_word[2*TAG_W+2:2*TAG_W+1];
  assign wp   = win_word[2*TAG_W+3];
  assign hit  = en && (((tag ^ base) & ~mask) == '0);
endmodule

// File: rtl/acc_attr_pick.sv
module acc_attr_pick #(
  parameter int NUM_WIN = 2
) (
  input  logic [NUM_WIN-1:0]   raw_hit,
  input  logic [2*NUM_WIN-1:0] win_mode,
  input  logic [NUM_WIN-1:0]   win_wp,
  input  logic [acc_attr_pkg::DFLT_W-1:0] dflt_word,
  input  logic                 is_instr,
  output logic [1:0]           mode,
  output logic                 wp,
  output logic [NUM_WIN-1:0]   sel_win
);
  always_comb begin
    mode    = is_instr ? dflt_word[3:2] : dflt_word[1:0];
    wp      = dflt_word[4];
    sel_win = '0;
    for (int i = NUM_WIN-1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        mode    = win_mode[2*i +: 2];
        wp      = win_wp[i];
        sel_win = NUM_WIN'(1) << i;
      end
    end
  end
endmodule

// File: rtl/acc_attr_unit.sv
module acc_attr_unit #(
  parameter int TAG_W   = 8,
  parameter int NUM_WIN = 2,
  localparam int WIN_W  = 2*TAG_W + 4,
  localparam int SEL_W  = $clog2(NUM_WIN + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [WIN_W-1:0]   cfg_wdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_instr,
  input  logic [TAG_W-1:0]   req_page,
  output logic [1:0]         res_mode,
  output logic               res_cacheable,
  output logic               res_wprot,
  output logic               res_violation,
  output logic [NUM_WIN-1:0] res_sel_win
);
  logic [NUM_WIN*WIN_W-1:0] win_flat;
  logic [acc_attr_pkg::DFLT_W-1:0] dflt_word;
  logic [NUM_WIN-1:0]   raw_hit, win_en, win_wp;
  logic [2*NUM_WIN-1:0] win_mode;

  acc_attr_regs #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .win_flat(win_flat), .dflt_word(dflt_word)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    acc_attr_match #(.TAG_W(TAG_W), .WIN_W(WIN_W)) u_match (
      .tag(req_page), .win_word(win_flat[i*WIN_W +: WIN_W]),
      .hit(raw_hit[i]), .en(win_en[i]),
      .mode(win_mode[2*i +: 2]), .wp(win_wp[i])
    );
  end

  acc_attr_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .raw_hit(raw_hit), .win_mode(win_mode), .win_wp(win_wp),
    .dflt_word(dflt_word), .is_instr(req_instr),
    .mode(res_mode), .wp(res_wprot), .sel_win(res_sel_win)
  );

  assign res_cacheable = acc_attr_pkg::mode_cacheable(res_mode);
  assign res_violation = req_valid && req_write && res_wprot;
endmodule

// File: rtl/acc_attr_chk.sv
module acc_attr_chk #(
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = 20,
  parameter int SEL_W   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic req_valid,
  input logic req_write,
  input logic [1:0] res_mode,
  input logic res_cacheable,
  input logic res_wprot,
  input logic res_violation,
  input logic [NUM_WIN-1:0] res_sel_win,
  input logic [NUM_WIN-1:0] raw_hit,
  input logic [NUM_WIN-1:0] win_en,
  input logic [NUM_WIN*WIN_W-1:0] win_flat,
  input logic [acc_attr_pkg::DFLT_W-1:0] dflt_word
);
  a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (win_flat == '0) && (dflt_word == '0));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_off
    a_r3_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en[i] |-> !raw_hit[i]);
  end

  a_r4_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_sel_win));

  a_r4_first_window_wins: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit[0] |-> res_sel_win[0]);

  a_r4_sel_backed_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_sel_win & ~raw_hit) == '0);

  a_r6_default_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit == '0) |-> (res_wprot == dflt_word[4]));

  a_r7_cacheable_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_cacheable != res_mode[1]);

  a_r8_violation_cause: assert property (@(posedge clk) disable iff (!rst_n)
    res_violation |-> (req_valid && req_write && res_wprot));

  a_r8_violation_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && res_wprot) |-> res_violation);

  a_r9_bad_target_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel > SEL_W'(NUM_WIN)) |=> ($stable(win_flat) && $stable(dflt_word)));
endmodule

bind acc_attr_unit acc_attr_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .req_valid(req_valid), .req_write(req_write), .res_mode(res_mode),
  .res_cacheable(res_cacheable), .res_wprot(res_wprot),
  .res_violation(res_violation), .res_sel_win(res_sel_win),
  .raw_hit(raw_hit), .win_en(win_en), .win_flat(win_flat), .dflt_word(dflt_word)
);

// File: tb/sim_acc_attr_unit.sv
module sim_acc_attr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_instr = 1'b0;
  logic [7:0] req_page = '0;
  logic [1:0] res_mode;
  logic res_cacheable, res_wprot, res_violation;
  logic [1:0] res_sel_win;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model state
  int m_base[2], m_mask[2], m_en[2], m_mode[2], m_wp[2];
  int m_dmode, m_imode, m_dwp;

  always #2 clk = ~clk;

  acc_attr_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_instr(req_instr), .req_page(req_page), .res_mode(res_mode),
    .res_cacheable(res_cacheable), .res_wprot(res_wprot),
    .res_violation(res_violation), .res_sel_win(res_sel_win)
  );

  function automatic logic [19:0] mkwin(int base, int mask, int en, int mode, int wp);
    return {wp[0], mode[1:0], en[0], mask[7:0], base[7:0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; m_mode[i] = 0; m_wp[i] = 0;
    end
    m_dmode = 0; m_imode = 0; m_dwp = 0;
  endtask

  task automatic model_write(int sel, logic [19:0] d);
    if (sel < 2) begin
      m_base[sel] = d[7:0]; m_mask[sel] = d[15:8]; m_en[sel] = d[16];
      m_mode[sel] = d[18:17]; m_wp[sel] = d[19];
    end else if (sel == 2) begin
      m_dmode = d[1:0]; m_imode = d[3:2]; m_dwp = d[4];
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d page=%02h t=%0t", tag, act, exp, req_page, $time);
    end
  endtask

  // one clock: drive at negedge, compare before the posedge, commit config after it
  task automatic cyc(bit we, int sel, logic [19:0] d, bit v, bit w, bit ins, int page);
    int emode, ewp, esel, win;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = d;
    req_valid = v; req_write = w; req_instr = ins; req_page = page[7:0];
    #1;
    win = -1;
    for (int i = 1; i >= 0; i--) begin
      // R2/R3: match on enabled window, masked bits ignored
      if (m_en[i] != 0 && ((page | m_mask[i]) & 255) == ((m_base[i] | m_mask[i]) & 255))
        win = i;
    end
    if (win >= 0) begin
      emode = m_mode[win]; ewp = m_wp[win]; esel = 1 << win;
    end else begin
      emode = ins ? m_imode : m_dmode; ewp = m_dwp; esel = 0;
    end
    check("R2 R5 mode", res_mode, emode);
    check("R4 sel_win", res_sel_win, esel);
    check("R6 wprot", res_wprot, ewp);
    check("R7 cacheable", res_cacheable, (emode == 0 || emode == 1) ? 1 : 0);
    check("R8 violation", res_violation, (v && w && ewp != 0) ? 1 : 0);
    @(posedge clk);
    if (we && rst_n) model_write(sel, d);   // R9
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, data read resolves to write-through, unprotected
    cyc(0, 0, 0, 1, 0, 0, 8'h12);
    cyc(0, 0, 0, 1, 1, 1, 8'hFF);
    // defaults: data copyback, instr inhibited-precise, protected (R5, R6, R8)
    cyc(1, 2, 20'h00019, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 8'h33);
    cyc(0, 0, 0, 1, 0, 1, 8'h33);
    cyc(0, 0, 0, 1, 1, 0, 8'h33);
    cyc(0, 0, 0, 0, 1, 0, 8'h33);
    // window 1: base 0x40, low nibble ignored, inhibited-imprecise, writable (R2)
    cyc(1, 1, mkwin(8'h40, 8'h0F, 1, 3, 0), 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 8'h45);
    cyc(0, 0, 0, 1, 1, 0, 8'h55);
    // R3: window 0 programmed over same base but disabled
    cyc(1, 0, mkwin(8'h40, 8'h00, 0, 0, 1), 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 8'h40);
    // R4: enable window 0 -> it wins on 0x40, window 1 still owns 0x41
    cyc(1, 0, mkwin(8'h40, 8'h00, 1, 0, 1), 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 8'h40);
    cyc(0, 0, 0, 1, 1, 0, 8'h41);
    // R9: target 3 writes nothing
    cyc(1, 3, 20'hFFFFF, 1, 1, 0, 8'h40);
    cyc(0, 0, 0, 1, 1, 0, 8'h40);
    cyc(0, 0, 0, 1, 0, 0, 8'h99);
    // random mix of config writes and references
    for (int k = 0; k < 3000; k++) begin
      int pg;
      bit we;
      pg = ($urandom % 4 == 0) ? int'($urandom % 256) : int'(8'h40 + ($urandom % 8) - 4);
      we = ($urandom % 6 == 0);
      cyc(we, $urandom % 4, 20'($urandom), $urandom % 2, $urandom % 2, $urandom % 2, pg);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule